// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This unit holds the fetch program counter of a 64-bit RISC core that has one architectural delay slot. On every cycle in which the pipeline advances, it gets the decoded control-transfer kind of the instruction at the current PC. It also gets the 26-bit jump field, the 16-bit branch offset, the value of register operand rs, the destination register number rd and the branch condition, which is computed elsewhere. From these it decides the address of the next instruction to fetch.

Every transfer takes effect one instruction late. The instruction after the transfer (the delay slot) is always fetched first, and the target lands in a one-entry pending register. The unit redirects to that target when the delay slot advances. The link forms report a register write of the post-slot return address in the cycle the transfer is accepted. The exchange jump flips an ISA-mode flag once its delay slot has gone by. A likely branch whose condition is false marks its delay slot as nullified.

Top module: `npc_unit`

## Requirements
- R1: Reset (rst_ni low, asynchronous) sets pc_o to RESET_PC, mode_o to 0, and drops any pending transfer. While no transfer is pending, nullify_o and link_we_o are 0.
- R2: When adv_i is high, ctl_i is 0 (no transfer) and no transfer is pending, pc_o advances by 4.
- R3: A transfer accepted at PC P always moves pc_o to P+4 (the delay slot) first. The next advance then moves pc_o to the transfer's resolved address.
- R4: ctl_i=1 (jump) and ctl_i=2/3 resolve to the address formed as follows: bits 63:60 are taken from P+4, bits 59:28 are zero, bits 27:2 hold the 26-bit field jtgt_i, and bits 1:0 are zero.
- R5: ctl_i=2 (jump-and-link) and ctl_i=3 raise link_we_o with link_idx_o=31 and link_val_o=P+8 in the accept cycle.
- R6: ctl_i=3 (exchange jump) inverts mode_o on the advance out of its delay slot, and not earlier.
- R7: ctl_i=4 (register jump) resolves to rs_val_i. ctl_i=5 resolves to rs_val_i and also writes P+8 to register rd_idx_i.
- R8: ctl_i=6 (branch) and ctl_i=7 (likely branch) with cond_i=1 resolve to P+4 plus off_i sign-extended and multiplied by 4. nullify_o stays 0.
- R9: A branch (ctl_i=6) with cond_i=0 resolves to P+8, and nullify_o stays 0 during its slot.
- R10: A likely branch (ctl_i=7) with cond_i=0 resolves to P+8, and nullify_o is 1 for exactly the cycles in which its delay slot is the current PC.
- R11: A transfer kind presented while a transfer is pending (that is, in a delay slot) is ignored: there is no link write and no change of the pending target.
- R12: With adv_i low, pc_o, mode_o and any pending transfer hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Instruction at pc_o issues this cycle |
| ctl_i | input | 3 | Transfer kind: 0 none, 1 J, 2 JAL, 3 JALX, 4 JR, 5 JALR, 6 branch, 7 likely branch |
| jtgt_i | input | 26 | Absolute jump field |
| off_i | input | 16 | Branch word offset |
| rs_val_i | input | 64 | Register jump source value |
| rd_idx_i | input | 5 | Link destination for the register jump-and-link |
| cond_i | input | 1 | Branch condition result |
| pc_o | output | 64 | Current fetch address |
| mode_o | output | 1 | ISA mode flag |
| nullify_o | output | 1 | Current instruction is a squashed delay slot |
| link_we_o | output | 1 | Link write valid |
| link_idx_o | output | 5 | Link register number |
| link_val_o | output | 64 | Link return address |

## Verification
The hardest situation to reach is a second transfer that arrives inside a delay slot while the first one is still pending. It must be ignored, with no link write, and the redirect must still go to the first target. The bench places a jump-and-link, then presents a register jump as the slot instruction. It also stalls adv_i while a target is pending and chains two exchange jumps, so that the mode flag goes round trip. Reset is also asserted while a target is pending, to show the redirect is dropped.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CTL_NONE = 3'd0,
    CTL_J    = 3'd1,
    CTL_JAL  = 3'd2,
    CTL_JALX = 3'd3,
    CTL_JR   = 3'd4,
    CTL_JALR = 3'd5,
    CTL_BR   = 3'd6,
    CTL_BRL  = 3'd7
  } ctl_e;
endpackage

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int JFIELD_W = 26,
  parameter int OFF_W   = 16
) (
  input  logic [XLEN-1:0]     pc_i,
  input  ctl_e                ctl_i,
  input  logic [JFIELD_W-1:0] jtgt_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [XLEN-1:0]     rs_val_i,
  input  logic                cond_i,
  output logic [XLEN-1:0]     tgt_o,
  output logic                null_o,
  output logic                tog_o,
  output logic                xfer_o
);
  localparam int HI_W  = 4;
  localparam int MID_W = XLEN - HI_W - JFIELD_W - 2;
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] pc4, pc8, jabs, boff, btgt;

  assign pc4  = pc_i + XLEN'(4);
  assign pc8  = pc_i + XLEN'(8);
  assign jabs = {pc4[XLEN-1 -: HI_W], {MID_W{1'b0}}, jtgt_i, 2'b00};
  assign boff = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign btgt = pc4 + boff;

  always_comb begin
    tgt_o  = pc8;
    null_o = 1'b0;
    tog_o  = 1'b0;
    xfer_o = 1'b1;
    unique case (ctl_i)
      CTL_J, CTL_JAL: tgt_o = jabs;
      CTL_JALX: begin
        tgt_o = jabs;
        tog_o = 1'b1;
      end
      CTL_JR, CTL_JALR: tgt_o = rs_val_i;
      CTL_BR:  tgt_o = cond_i ? btgt : pc8;
      CTL_BRL: begin
        tgt_o  = cond_i ? btgt : pc8;
        null_o = ~cond_i;
      end
      default: xfer_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int REG_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic             accept_i,
  input  ctl_e             ctl_i,
  input  logic [REG_W-1:0] rd_idx_i,
  input  logic [XLEN-1:0]  pc_i,
  output logic             we_o,
  output logic [REG_W-1:0] idx_o,
  output logic [XLEN-1:0]  val_o
);
  always_comb begin
    we_o  = 1'b0;
    idx_o = REG_W'(LINK_REG);
    if (accept_i) begin
      unique case (ctl_i)
        CTL_JAL, CTL_JALX: we_o = 1'b1;
        CTL_JALR: begin
          we_o  = 1'b1;
          idx_o = rd_idx_i;
        end
        default: we_o = 1'b0;
      endcase
    end
  end

  // return address skips the delay slot
  assign val_o = pc_i + XLEN'(8);
endmodule

// File: rtl/npc_pend.sv
module npc_pend #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            fire_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic            null_i,
  input  logic            tog_i,
  output logic            vld_o,
  output logic [XLEN-1:0] tgt_o,
  output logic            null_o,
  output logic            tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      tgt_o  <= '0;
      null_o <= 1'b0;
      tog_o  <= 1'b0;
    end else if (arm_i) begin
      vld_o  <= 1'b1;
      tgt_o  <= tgt_i;
      null_o <= null_i;
      tog_o  <= tog_i;
    end else if (fire_i) begin
      vld_o  <= 1'b0;
      null_o <= 1'b0;
      tog_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              REG_W    = 5,
  parameter int              LINK_REG = 31,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [2:0]       ctl_i,
  input  logic [25:0]      jtgt_i,
  input  logic [15:0]      off_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [REG_W-1:0] rd_idx_i,
  input  logic             cond_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             mode_o,
  output logic             nullify_o,
  output logic             link_we_o,
  output logic [REG_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_val_o
);
  ctl_e            ctl;
  logic [XLEN-1:0] pc_q, new_tgt, pend_tgt;
  logic            new_null, new_tog, is_xfer;
  logic            slot_q, pend_null, pend_tog;
  logic            accept, fire, arm;
  logic            mode_q;

  assign ctl    = ctl_e'(ctl_i);
  assign accept = adv_i & ~slot_q;
  assign fire   = adv_i & slot_q;
  assign arm    = accept & is_xfer;

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc_i    (pc_q),
    .ctl_i   (ctl),
    .jtgt_i  (jtgt_i),
    .off_i   (off_i),
    .rs_val_i(rs_val_i),
    .cond_i  (cond_i),
    .tgt_o   (new_tgt),
    .null_o  (new_null),
    .tog_o   (new_tog),
    .xfer_o  (is_xfer)
  );

  npc_pend #(.XLEN(XLEN)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .fire_i(fire),
    .tgt_i (new_tgt),
    .null_i(new_null),
    .tog_i (new_tog),
    .vld_o (slot_q),
    .tgt_o (pend_tgt),
    .null_o(pend_null),
    .tog_o (pend_tog)
  );

  npc_link #(.XLEN(XLEN), .REG_W(REG_W), .LINK_REG(LINK_REG)) u_link (
    .accept_i(accept),
    .ctl_i   (ctl),
    .rd_idx_i(rd_idx_i),
    .pc_i    (pc_q),
    .we_o    (link_we_o),
    .idx_o   (link_idx_o),
    .val_o   (link_val_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= RESET_PC;
      mode_q <= 1'b0;
    end else if (adv_i) begin
      pc_q <= fire ? pend_tgt : pc_q + XLEN'(4);
      if (fire && pend_tog) mode_q <= ~mode_q;
    end
  end

  assign pc_o      = pc_q;
  assign mode_o    = mode_q;
  assign nullify_o = slot_q & pend_null;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            adv_i,
  input logic [2:0]      ctl_i,
  input logic [XLEN-1:0] pc_o,
  input logic            mode_o,
  input logic            nullify_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o,
  input logic            slot_i
);
  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !slot_i && ctl_i == 3'd0 |=> pc_o == $past(pc_o) + XLEN'(4));

  p_slot_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !slot_i && ctl_i != 3'd0 |=> slot_i && pc_o == $past(pc_o) + XLEN'(4));

  p_link_val_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_val_o == pc_o + XLEN'(8));

  p_mode_late_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i && slot_i) |=> $stable(mode_o));

  p_null_in_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nullify_o |-> slot_i);

  p_slot_no_link_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |-> !link_we_o);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pc_o) && $stable(slot_i));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adv_i     (adv_i),
  .ctl_i     (ctl_i),
  .pc_o      (pc_o),
  .mode_o    (mode_o),
  .nullify_o (nullify_o),
  .link_we_o (link_we_o),
  .link_val_o(link_val_o),
  .slot_i    (slot_q)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam logic [63:0] RP = 64'hF000_0000_0000_1000;
  localparam int NV = 10;

  typedef struct packed {
    logic [2:0]  ctl;
    logic [25:0] imm;
    logic [63:0] rs;
    logic [4:0]  rd;
    logic        cond;
    logic [63:0] tgt;
    logic        we;
    logic [4:0]  idx;
    logic        nul;
    logic        mode;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd1, 26'h0000040, 64'h0, 5'd0, 1'b0, 64'hF000_0000_0000_0100, 1'b0, 5'd0,  1'b0, 1'b0},
    '{3'd2, 26'h3FFFFFF, 64'h0, 5'd0, 1'b0, 64'hF000_0000_0FFF_FFFC, 1'b1, 5'd31, 1'b0, 1'b0},
    '{3'd3, 26'h0000123, 64'h0, 5'd0, 1'b0, 64'hF000_0000_0000_048C, 1'b1, 5'd31, 1'b0, 1'b1},
    '{3'd4, 26'h0, 64'h1234_5678_9ABC_DEF0, 5'd0, 1'b0, 64'h1234_5678_9ABC_DEF0, 1'b0, 5'd0, 1'b0, 1'b0},
    '{3'd5, 26'h0, 64'h0000_0000_0000_2000, 5'd7, 1'b0, 64'h0000_0000_0000_2000, 1'b1, 5'd7, 1'b0, 1'b0},
    '{3'd6, 26'h0010, 64'h0, 5'd0, 1'b1, 64'hF000_0000_0000_1044, 1'b0, 5'd0, 1'b0, 1'b0},
    '{3'd6, 26'hFFFF, 64'h0, 5'd0, 1'b1, 64'hF000_0000_0000_1000, 1'b0, 5'd0, 1'b0, 1'b0},
    '{3'd6, 26'h0010, 64'h0, 5'd0, 1'b0, 64'hF000_0000_0000_1008, 1'b0, 5'd0, 1'b0, 1'b0},
    '{3'd7, 26'h8000, 64'h0, 5'd0, 1'b1, 64'hEFFF_FFFF_FFFE_1004, 1'b0, 5'd0, 1'b0, 1'b0},
    '{3'd7, 26'h0010, 64'h0, 5'd0, 1'b0, 64'hF000_0000_0000_1008, 1'b0, 5'd0, 1'b1, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adv_i = 1'b0;
  logic [2:0]  ctl_i = '0;
  logic [25:0] jtgt_i = '0;
  logic [15:0] off_i = '0;
  logic [63:0] rs_val_i = '0;
  logic [4:0]  rd_idx_i = '0;
  logic        cond_i = 1'b0;
  logic [63:0] pc_o, link_val_o;
  logic        mode_o, nullify_o, link_we_o;
  logic [4:0]  link_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  npc_unit #(.RESET_PC(RP)) uut (
    .clk_i, .rst_ni, .adv_i, .ctl_i, .jtgt_i, .off_i, .rs_val_i, .rd_idx_i, .cond_i,
    .pc_o, .mode_o, .nullify_o, .link_we_o, .link_idx_o, .link_val_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    adv_i = 1'b0;
    ctl_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic drive(input logic a, input logic [2:0] c, input logic [25:0] imm,
                       input logic [63:0] rs, input logic [4:0] rd, input logic cd);
    @(negedge clk_i);
    adv_i = a;
    ctl_i = c;
    jtgt_i = imm;
    off_i = imm[15:0];
    rs_val_i = rs;
    rd_idx_i = rd;
    cond_i = cd;
    #1;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R1 pc", pc_o, RP);
    chk("R1 mode", 64'(mode_o), 0);
    chk("R1 nullify", 64'(nullify_o), 0);
    chk("R1 link_we", 64'(link_we_o), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      drive(1'b1, VECS[i].ctl, VECS[i].imm, VECS[i].rs, VECS[i].rd, VECS[i].cond);
      chk("R5/R7 link_we", 64'(link_we_o), 64'(VECS[i].we));
      if (VECS[i].we) begin
        chk("R5/R7 link_idx", 64'(link_idx_o), 64'(VECS[i].idx));
        chk("R5 link_val", link_val_o, RP + 64'd8);
      end
      tick();
      chk("R3 slot pc", pc_o, RP + 64'd4);
      chk("R10 nullify in slot", 64'(nullify_o), 64'(VECS[i].nul));
      chk("R6 mode before slot", 64'(mode_o), 0);
      drive(1'b1, 3'd0, '0, '0, '0, 1'b0);
      tick();
      chk("R4/R7/R8/R9 target", pc_o, VECS[i].tgt);
      chk("R6 mode after slot", 64'(mode_o), 64'(VECS[i].mode));
      chk("R10 nullify cleared", 64'(nullify_o), 0);
    end

    // R2 sequential
    do_reset();
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 3'd0, '0, '0, '0, 1'b0);
      tick();
    end
    chk("R2 sequential", pc_o, RP + 64'd12);

    // R12 stall with a pending target
    do_reset();
    drive(1'b1, 3'd1, 26'h40, '0, '0, 1'b0);
    tick();
    drive(1'b0, 3'd0, '0, '0, '0, 1'b0);
    tick();
    tick();
    chk("R12 hold pc", pc_o, RP + 64'd4);
    drive(1'b1, 3'd0, '0, '0, '0, 1'b0);
    tick();
    chk("R12 pending kept", pc_o, 64'hF000_0000_0000_0100);

    // R11 transfer inside the delay slot
    do_reset();
    drive(1'b1, 3'd2, 26'h40, '0, '0, 1'b0);
    tick();
    drive(1'b1, 3'd4, '0, 64'hDEAD_0000, 5'd3, 1'b0);
    chk("R11 no link in slot", 64'(link_we_o), 0);
    tick();
    chk("R11 first target wins", pc_o, 64'hF000_0000_0000_0100);

    // R6 two exchange jumps return mode to 0
    do_reset();
    drive(1'b1, 3'd3, 26'h40, '0, '0, 1'b0);
    tick();
    drive(1'b1, 3'd0, '0, '0, '0, 1'b0);
    tick();
    chk("R6 mode set", 64'(mode_o), 1);
    drive(1'b1, 3'd3, 26'h80, '0, '0, 1'b0);
    tick();
    chk("R6 mode held in slot", 64'(mode_o), 1);
    drive(1'b1, 3'd0, '0, '0, '0, 1'b0);
    tick();
    chk("R6 mode cleared", 64'(mode_o), 0);
    chk("R4 second jump", pc_o, 64'hF000_0000_0000_0200);

    // R1 reset drops a pending transfer
    do_reset();
    drive(1'b1, 3'd1, 26'h40, '0, '0, 1'b0);
    tick();
    do_reset();
    drive(1'b1, 3'd0, '0, '0, '0, 1'b0);
    tick();
    chk("R1 pending dropped", pc_o, RP + 64'd4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule